// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block chooses the three settings of a fractional-free clock synthesiser: a reference divider M, a feedback multiplier N and a post-divider selected through a table index PL. It is given the requested output frequency and the reference frequency, both in kHz. It walks the post-divider range, and for each post-divider it walks the reference divider and a pair of candidate multipliers. It keeps the candidate whose rounded output is nearest the working target, which is twice the request. Every candidate must respect the limits on the phase-comparison frequency and on the oscillator (VCO) frequency.

The search is iterative. All quotients come from one shared restoring divider that produces one quotient bit per cycle, so a result takes from a few hundred to several thousand cycles. The search stops as soon as a candidate lands exactly on target.

Requests enter on a valid/ready port. `in_ready` is high only while the engine is idle, and a request is taken on a cycle where both `in_valid` and `in_ready` are high. The result leaves on a valid/ready port. Once `out_valid` rises, it and every result field hold steady until the consumer raises `out_ready`. No new request is taken until that has happened. `busy` is a plain status pin that marks a search in progress.

Top module: `pllsrch_engine`

## Requirements
- R1: After reset, `in_ready` is 1, while `out_valid` and `busy` are 0.
- R2: A request is taken only when `in_valid` and `in_ready` are both high. From the next cycle until `out_valid` rises, `busy` is 1 and `in_ready` is 0. Any `in_valid` seen during that time is ignored.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and all result fields stay unchanged.
- R4: The target is T = 2·request. The preliminary VCO value is P = T + floor(T/50). The lowest index is derived from floor(1,000,000/P) and the highest from ceil(Vmax/P). Each bound is first clamped to 1..32, then mapped to the first table index whose ratio is at least that value, or to index 14 if no entry is.
- R5: The comparison frequency is floor(ref/M), with M counted up from 1 to 255. A value below 12,000 ends the M loop for the current index. A value above 38,000 skips that M.
- R6: For each M the candidate N runs from floor(ratio·T·M/ref) up to the matching ceiling. A floor above 255 ends the M loop. N below 8 is skipped, and N above 255 ends the candidates for that M.
- R7: A candidate counts only if VCO = floor(ref·N/M) lies within 1,000,000..Vmax, where Vmax = max(2,064,000, P).
- R8: The candidate output is floor((VCO + floor(ratio/2))/ratio) and its error is |output − T|. Indices are searched in ascending order, then M, then N. A candidate replaces the best only if its error is strictly smaller.
- R9: A zero error ends the search at once. `out_exact` is 1 exactly when a match was found with zero error.
- R10: If no candidate counts, the result is M=255, N=8, PL=1, `out_found`=0, `out_exact`=0, and `out_err` is all ones.
- R11: `out_pl` is the table index 0..14, whose ratios in order are 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine idle and able to take a request |
| in_req_khz | input | IN_W | Requested output frequency, kHz |
| in_ref_khz | input | IN_W | Reference frequency, kHz |
| busy | output | 1 | Search in progress |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_m | output | MN_W | Chosen reference divider |
| out_n | output | MN_W | Chosen feedback multiplier |
| out_pl | output | PL_W | Chosen post-divider table index |
| out_err | output | W | Absolute error in kHz of the doubled target |
| out_exact | output | 1 | Zero-error match |
| out_found | output | 1 | At least one candidate qualified |

## Verification
The bench builds the engine with its default parameters: a 40-bit datapath, 24-bit inputs, the full 1..255 divider and 8..255 multiplier ranges, and the standard frequency windows. With these values, references from 10 to 38.4 MHz and requests up to about 1.1 GHz can be driven. That covers several cases: a reference too slow for any comparison frequency, a first M skipped for a comparison frequency that is too fast, a request large enough to widen the VCO window, and the early stop on an exact hit. Hand-computed vectors pin the tie and bound behaviour. A sweep over further reference/request pairs is checked against a model written from the requirements.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

  localparam int unsigned RATIO_W = 6;
  localparam int unsigned PL_LAST = 14;

  typedef enum logic [3:0] {
    S_IDLE, S_PVCO, S_HI, S_LO, S_PL, S_UF, S_NF, S_NCHK, S_VCO, S_LWV, S_DONE
  } srch_state_e;

  // post-divide ratio per table index; out-of-table index yields 1
  function automatic logic [RATIO_W-1:0] pl_ratio(input logic [3:0] idx);
    case (idx)
      4'd0:  pl_ratio = 6'd1;
      4'd1:  pl_ratio = 6'd2;
      4'd2:  pl_ratio = 6'd3;
      4'd3:  pl_ratio = 6'd4;
      4'd4:  pl_ratio = 6'd5;
      4'd5:  pl_ratio = 6'd6;
      4'd6:  pl_ratio = 6'd8;
      4'd7:  pl_ratio = 6'd10;
      4'd8:  pl_ratio = 6'd12;
      4'd9:  pl_ratio = 6'd16;
      4'd10: pl_ratio = 6'd12;
      4'd11: pl_ratio = 6'd16;
      4'd12: pl_ratio = 6'd20;
      4'd13: pl_ratio = 6'd24;
      4'd14: pl_ratio = 6'd32;
      default: pl_ratio = 6'd1;
    endcase
  endfunction

endpackage

// File: rtl/pllsrch_divider.sv
module pllsrch_divider #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  q_r, r_r, b_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted, diff;
  logic          fits;

  assign shifted = {r_r, q_r[W-1]};
  assign fits    = shifted >= {1'b0, b_r};
  assign diff    = shifted - {1'b0, b_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r  <= '0;
      r_r  <= '0;
      b_r  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_r <= dividend;
        r_r <= '0;
        b_r <= divisor;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        r_r <= fits ? diff[W-1:0] : shifted[W-1:0];
        q_r <= {q_r[W-2:0], fits};
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = q_r;
  assign rem  = r_r;

  // R6: the remainder feeding the ceiling step is below the divisor
  p_rem_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && b_r != '0) |-> (r_r < b_r));

endmodule

// File: rtl/pllsrch_bound.sv
module pllsrch_bound
  import pllsrch_pkg::*;
#(
  parameter int unsigned W       = 40,
  parameter int unsigned DIV_MIN = 1,
  parameter int unsigned DIV_MAX = 32,
  parameter int unsigned PL_W    = 4
) (
  input  logic [W-1:0]    ratio_in,
  output logic [PL_W-1:0] idx_out
);
  logic [RATIO_W-1:0] clamped;

  always_comb begin
    if (ratio_in < W'(DIV_MIN))
      clamped = RATIO_W'(DIV_MIN);
    else if (ratio_in > W'(DIV_MAX))
      clamped = RATIO_W'(DIV_MAX);
    else
      clamped = ratio_in[RATIO_W-1:0];
    idx_out = PL_W'(PL_LAST);
    for (int i = PL_LAST - 1; i >= 0; i--) begin
      if (pl_ratio(4'(i)) >= clamped) idx_out = PL_W'(i);
    end
  end

endmodule

// File: rtl/pllsrch_engine.sv
module pllsrch_engine
  import pllsrch_pkg::*;
#(
  parameter int unsigned IN_W      = 24,
  parameter int unsigned W         = 40,
  parameter int unsigned MN_W      = 8,
  parameter int unsigned PL_W      = 4,
  parameter int unsigned M_MAX     = 255,
  parameter int unsigned N_MIN     = 8,
  parameter int unsigned N_MAX     = 255,
  parameter int unsigned VCO_MIN   = 1000000,
  parameter int unsigned VCO_MAX   = 2064000,
  parameter int unsigned CMP_MIN   = 12000,
  parameter int unsigned CMP_MAX   = 38000,
  parameter int unsigned DIV_MIN   = 1,
  parameter int unsigned DIV_MAX   = 32,
  parameter int unsigned SLACK_DEN = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_req_khz,
  input  logic [IN_W-1:0] in_ref_khz,
  output logic            busy,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [MN_W-1:0] out_m,
  output logic [MN_W-1:0] out_n,
  output logic [PL_W-1:0] out_pl,
  output logic [W-1:0]    out_err,
  output logic            out_exact,
  output logic            out_found
);
  localparam logic [W-1:0] VMIN_W = W'(VCO_MIN);
  localparam logic [W-1:0] VMAX_W = W'(VCO_MAX);
  localparam logic [W-1:0] CMIN_W = W'(CMP_MIN);
  localparam logic [W-1:0] CMAX_W = W'(CMP_MAX);
  localparam logic [W-1:0] NMIN_W = W'(N_MIN);
  localparam logic [W-1:0] NMAX_W = W'(N_MAX);

  srch_state_e     state;
  logic            issued;
  logic [W-1:0]    tgt, refk, pvco, maxv, n_cur, n_top, vco;
  logic [PL_W-1:0] hi_idx, pl_idx, best_pl, bound_idx;
  logic [MN_W-1:0] m_cnt, best_m, best_n;
  logic [W-1:0]    best_err;
  logic            found;

  logic            div_start, div_done, div_state;
  logic [W-1:0]    div_a, div_b, div_q, div_r;
  logic [W-1:0]    ratio, vt, delta, pv_next;
  logic            m_last;

  assign ratio   = W'(pl_ratio(4'(pl_idx)));
  assign vt      = tgt * ratio;
  assign delta   = (div_q >= tgt) ? (div_q - tgt) : (tgt - div_q);
  assign pv_next = tgt + div_q;
  assign m_last  = (m_cnt == MN_W'(M_MAX));

  assign div_state = (state == S_PVCO) || (state == S_HI) || (state == S_LO) ||
                     (state == S_UF) || (state == S_NF) || (state == S_VCO) ||
                     (state == S_LWV);
  assign div_start = div_state && !issued;

  always_comb begin
    div_a = '0;
    div_b = W'(1);
    case (state)
      S_PVCO: begin div_a = tgt;                     div_b = W'(SLACK_DEN); end
      S_HI:   begin div_a = maxv + pvco - W'(1);     div_b = pvco;          end
      S_LO:   begin div_a = VMIN_W;                  div_b = pvco;          end
      S_UF:   begin div_a = refk;                    div_b = W'(m_cnt);     end
      S_NF:   begin div_a = vt * W'(m_cnt);          div_b = refk;          end
      S_VCO:  begin div_a = refk * n_cur;            div_b = W'(m_cnt);     end
      S_LWV:  begin div_a = vco + (ratio >> 1);      div_b = ratio;         end
      default: ;
    endcase
  end

  pllsrch_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(div_a), .divisor(div_b),
    .done(div_done), .quot(div_q), .rem(div_r)
  );

  pllsrch_bound #(.W(W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .PL_W(PL_W)) u_bound (
    .ratio_in(div_q), .idx_out(bound_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      issued   <= 1'b0;
      tgt      <= '0;
      refk     <= '0;
      pvco     <= '0;
      maxv     <= '0;
      hi_idx   <= '0;
      pl_idx   <= '0;
      m_cnt    <= '0;
      n_cur    <= '0;
      n_top    <= '0;
      vco      <= '0;
      best_m   <= MN_W'(M_MAX);
      best_n   <= MN_W'(N_MIN);
      best_pl  <= PL_W'(1);
      best_err <= '1;
      found    <= 1'b0;
    end else begin
      if (div_start) issued <= 1'b1;
      if (div_done)  issued <= 1'b0;
      case (state)
        S_IDLE: if (in_valid) begin
          tgt      <= W'(in_req_khz) << 1;
          refk     <= W'(in_ref_khz);
          best_m   <= MN_W'(M_MAX);
          best_n   <= MN_W'(N_MIN);
          best_pl  <= PL_W'(1);
          best_err <= '1;
          found    <= 1'b0;
          state    <= S_PVCO;
        end
        S_PVCO: if (div_done) begin
          pvco  <= pv_next;
          maxv  <= (pv_next > VMAX_W) ? pv_next : VMAX_W;
          state <= S_HI;
        end
        S_HI: if (div_done) begin
          hi_idx <= bound_idx;
          state  <= S_LO;
        end
        S_LO: if (div_done) begin
          pl_idx <= bound_idx;
          state  <= S_PL;
        end
        S_PL: begin
          if (pl_idx > hi_idx) state <= S_DONE;
          else begin
            m_cnt <= MN_W'(1);
            state <= S_UF;
          end
        end
        S_UF: if (div_done) begin
          if (div_q < CMIN_W) begin
            pl_idx <= pl_idx + PL_W'(1);
            state  <= S_PL;
          end else if (div_q > CMAX_W) begin
            if (m_last) begin
              pl_idx <= pl_idx + PL_W'(1);
              state  <= S_PL;
            end else begin
              m_cnt <= m_cnt + MN_W'(1);
            end
          end else begin
            state <= S_NF;
          end
        end
        S_NF: if (div_done) begin
          if (div_q > NMAX_W) begin
            pl_idx <= pl_idx + PL_W'(1);
            state  <= S_PL;
          end else begin
            n_cur <= div_q;
            n_top <= div_q + W'(div_r != '0);
            state <= S_NCHK;
          end
        end
        S_NCHK: begin
          if (n_cur > n_top || n_cur > NMAX_W) begin
            if (m_last) begin
              pl_idx <= pl_idx + PL_W'(1);
              state  <= S_PL;
            end else begin
              m_cnt <= m_cnt + MN_W'(1);
              state <= S_UF;
            end
          end else if (n_cur < NMIN_W) begin
            n_cur <= n_cur + W'(1);
          end else begin
            state <= S_VCO;
          end
        end
        S_VCO: if (div_done) begin
          if (div_q >= VMIN_W && div_q <= maxv) begin
            vco   <= div_q;
            state <= S_LWV;
          end else begin
            n_cur <= n_cur + W'(1);
            state <= S_NCHK;
          end
        end
        S_LWV: if (div_done) begin
          if (delta < best_err) begin
            best_err <= delta;
            best_m   <= m_cnt;
            best_n   <= n_cur[MN_W-1:0];
            best_pl  <= pl_idx;
            found    <= 1'b1;
          end
          if (delta == '0) state <= S_DONE;
          else begin
            n_cur <= n_cur + W'(1);
            state <= S_NCHK;
          end
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == S_IDLE);
  assign out_valid = (state == S_DONE);
  assign busy      = (state != S_IDLE) && (state != S_DONE);
  assign out_m     = best_m;
  assign out_n     = best_n;
  assign out_pl    = best_pl;
  assign out_err   = best_err;
  assign out_found = found;
  assign out_exact = found && (best_err == '0);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !in_ready));

  p_result_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_m) && $stable(out_n) &&
                                   $stable(out_pl) && $stable(out_err) && $stable(out_found)));

  p_ncand_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VCO) |-> (n_cur >= NMIN_W && n_cur <= NMAX_W && n_cur <= n_top));

  p_vco_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LWV) |-> (vco >= VMIN_W && vco <= maxv));

  p_nomatch_default_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_found) |-> (out_m == MN_W'(M_MAX) && out_n == MN_W'(N_MIN) &&
                                   out_pl == PL_W'(1) && !out_exact));

  p_pl_in_table_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pl <= PL_W'(PL_LAST)));

endmodule

// File: tb/pllsrch_engine_bench.sv
`timescale 1ns/1ps
module pllsrch_engine_bench;
  localparam int W = 40;
  localparam longint ALL1 = (longint'(1) << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [23:0] in_req = '0, in_ref = '0;
  logic in_ready, busy, out_valid, out_exact, out_found;
  logic [7:0] out_m, out_n;
  logic [3:0] out_pl;
  logic [W-1:0] out_err;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pllsrch_engine u_pllsrch_engine (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_req_khz(in_req), .in_ref_khz(in_ref),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
    .out_m(out_m), .out_n(out_n), .out_pl(out_pl), .out_err(out_err),
    .out_exact(out_exact), .out_found(out_found)
  );

  // hand-computed vectors: req, ref, m, n, pl, err, found
  localparam int VN = 5;
  localparam longint V_REQ [VN] = '{72000, 100000, 100000, 1100000, 100000};
  localparam longint V_REF [VN] = '{12000, 10000, 13000, 12000, 38400};
  localparam longint V_M   [VN] = '{1, 255, 1, 1, 3};
  localparam longint V_N   [VN] = '{96, 8, 123, 183, 125};
  localparam longint V_PL  [VN] = '{6, 1, 6, 0, 6};
  localparam longint V_ERR [VN] = '{0, ALL1, 125, 4000, 0};
  localparam bit     V_FND [VN] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  localparam int SN = 8;
  localparam longint S_REQ [SN] = '{180000, 252000, 396000, 540000, 612000, 852000, 324000, 468000};
  localparam longint S_REF [SN] = '{12000, 19200, 38400, 12800, 38400, 19200, 13000, 38400};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint b_ratio(input int i);
    case (i)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;  4: return 5;
      5: return 6;  6: return 8;  7: return 10; 8: return 12; 9: return 16;
      10: return 12; 11: return 16; 12: return 20; 13: return 24; 14: return 32;
      default: return 1;
    endcase
  endfunction

  function automatic int b_idx(input longint v);
    longint c = (v < 1) ? 1 : (v > 32) ? 32 : v;
    for (int i = 0; i < 14; i++) if (b_ratio(i) >= c) return i;
    return 14;
  endfunction

  // search model built from R4..R10
  task automatic model(input longint rq, input longint rf, output longint em, output longint en,
                       output longint epl, output longint eerr, output bit efound);
    longint t, pv, mx, r, vt, uf, n, n2, vco, lwv, d;
    int lo, hi;
    bit stop;
    t = 2 * rq; pv = t + t / 50; mx = (pv > 2064000) ? pv : 2064000;
    hi = b_idx((mx + pv - 1) / pv);
    lo = b_idx(1000000 / pv);
    em = 255; en = 8; epl = 1; eerr = ALL1; efound = 1'b0; stop = 1'b0;
    for (int pl = lo; pl <= hi && !stop; pl++) begin
      r = b_ratio(pl); vt = t * r;
      for (int m = 1; m <= 255 && !stop; m++) begin
        uf = rf / m;
        if (uf < 12000) break;
        if (uf > 38000) continue;
        n = vt * m / rf; n2 = (vt * m + rf - 1) / rf;
        if (n > 255) break;
        for (; n <= n2 && !stop; n++) begin
          if (n < 8) continue;
          if (n > 255) break;
          vco = rf * n / m;
          if (vco >= 1000000 && vco <= mx) begin
            lwv = (vco + r / 2) / r;
            d = (lwv >= t) ? lwv - t : t - lwv;
            if (d < eerr) begin
              eerr = d; em = m; en = n; epl = pl; efound = 1'b1;
            end
            if (d == 0) stop = 1'b1;
          end
        end
      end
    end
  endtask

  longint g_m, g_n, g_pl, g_err;
  bit g_found, g_exact, g_ok;

  task automatic do_req(input longint rq, input longint rf, input int hold, input bit noise);
    int cyc;
    @(negedge clk);
    in_req = 24'(rq); in_ref = 24'(rf); in_valid = 1'b1;
    @(negedge clk);
    if (noise) begin
      in_req = 24'(rq + 12345); in_ref = 24'(rf / 2);
    end else in_valid = 1'b0;
    chk(busy && !in_ready, "R2 busy after accept", {busy, in_ready}, 2);
    cyc = 0;
    while (!out_valid && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (noise && cyc == 50) chk(!in_ready, "R2 in_ready low while busy", in_ready, 0);
    end
    in_valid = 1'b0;
    g_ok = out_valid;
    chk(out_valid, "R2 result timeout", out_valid, 1);
    g_m = out_m; g_n = out_n; g_pl = out_pl; g_err = out_err;
    g_found = out_found; g_exact = out_exact;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(out_valid && out_m == g_m && out_n == g_n && out_pl == g_pl &&
          out_err == g_err && out_found == g_found, "R3 hold under back-pressure",
          out_valid, 1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R2 idle after result taken", in_ready, 1);
  endtask

  task automatic cmp(input string tag, input longint em, input longint en, input longint epl,
                     input longint eerr, input bit efound);
    chk(g_m == em,   {tag, " m"},   g_m, em);
    chk(g_n == en,   {tag, " n"},   g_n, en);
    chk(g_pl == epl, {tag, " pl"},  g_pl, epl);
    chk(g_err == eerr, {tag, " err"}, g_err, eerr);
    chk(g_found == efound, {tag, " found"}, g_found, efound);
    chk(g_exact == (efound && eerr == 0), {tag, " exact R9"}, g_exact, efound && eerr == 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint em, en, epl, eerr;
    bit ef;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !busy && !out_valid, "R1 idle after reset release", in_ready, 1);

    // vector table: v0 exact at index 6 (R4 R5 R9 R11); v1 ref too slow -> no match (R10);
    // v2 inexact best error 125 (R8); v3 widened window Vmax=P (R7);
    // v4 M=1 skipped as comparison > 38000, exact at M=3 (R5 R6)
    for (int v = 0; v < VN; v++) begin
      do_req(V_REQ[v], V_REF[v], 0, 1'b0);
      cmp($sformatf("R8 vec%0d", v), V_M[v], V_N[v], V_PL[v], V_ERR[v], V_FND[v]);
    end

    // R3: back-pressure hold, R2: noise on in_valid during search ignored
    do_req(100000, 13000, 6, 1'b1);
    cmp("R2 R3 noise/hold", 1, 123, 6, 125, 1'b1);

    // sweep against the requirement model (R4 R5 R6 R7 R8)
    for (int s = 0; s < SN; s++) begin
      model(S_REQ[s], S_REF[s], em, en, epl, eerr, ef);
      do_req(S_REQ[s], S_REF[s], 0, 1'b0);
      cmp($sformatf("R4 sweep%0d", s), em, en, epl, eerr, ef);
      chk(g_pl <= 14, "R11 index in table", g_pl, 14);
    end

    // R10 again after a matching run: defaults restored per request
    do_req(200000, 11000, 2, 1'b0);
    cmp("R10 no match", 255, 8, 1, ALL1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule